// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit linear address into a 32-bit physical address for 4 KB pages. It walks a two-level table held in memory, reached through one read/write port. A request carries the linear address plus two qualifiers: whether the access is a write and whether it comes from user level.

The walk starts at the directory base register. It reads the directory entry and then the table entry. It writes the accessed and dirty status bits back into memory where they change. It ends with either a physical address or a page fault.

When a walk faults, its linear address is kept in a fault-address register until the next fault. The block accepts a new request whenever it is idle, and it reports each outcome as a one-cycle response pulse.

Entry bit positions: bit 0 present (P), bit 1 writable (RW), bit 2 user-allowed (US), bit 5 accessed (A), bit 6 dirty (D), bits 31..12 frame number.

Top module: `pt_walker`

## Requirements
- R1: Loading the base register clears its low 12 bits. The directory entry is read at {base[31:12], 12'b0} + 4 * linear[31:22].
- R2: The table entry is read at {directory frame, 12'b0} + 4 * linear[21:12].
- R3: A walk that does not fault returns resp_fault=0 and a physical address equal to {table frame, linear[11:0]}.
- R4: If P=0 in the directory entry, the walk faults with no further memory access. If P=0 in the table entry, the walk faults without writing that entry.
- R5: A supervisor access is never refused by the protection bits. A user access needs US=1 at both levels. A user write also needs RW=1 at both levels. A violation faults, and nothing is written at or after the level that refused.
- R6: After a present and permitted directory entry is read with A=0, the same address is written with A set and every other bit unchanged. If A is already 1, no write is made.
- R7: After a present and permitted table entry is read, one write sets A, and also sets D when the access is a write. The write happens only if at least one of these bits changes; otherwise the entry is not written.
- R8: The directory entry's D bit is never set by the walker.
- R9: Every fault loads fault_addr with the faulting linear address. fault_addr does not change otherwise.
- R10: After reset the block is idle: req_ready=1, mem_req=0, resp_valid=0 and fault_addr=0. A memory request holds its address, direction and data until mem_ack. resp_valid lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr | input | 1 | Load the directory base register |
| base_in | input | 32 | New directory base (low 12 bits discarded) |
| req_valid | input | 1 | Start a walk (taken when req_ready) |
| req_ready | output | 1 | Walker idle |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Entry write data |
| mem_rdata | input | 32 | Entry read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes this cycle |
| resp_valid | output | 1 | Walk result pulse |
| resp_fault | output | 1 | Walk ended in a page fault |
| resp_paddr | output | 32 | Physical address (zero on fault) |
| fault_addr | output | 32 | Linear address of the most recent fault |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses, 4 KB pages and the bit positions listed above. These defaults bring the full 10+10+12 index split within reach, so directory and table indices at both ends of their range are used.

The bench memory acknowledges after one, two or three cycles. This exercises request holding across stalls and back-to-back read-then-write of the same entry. Directed walks cover every fault level and every protection combination. Seeded random walks over a small shared table set reach the cases where accessed and dirty bits are already set.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW      = 32,
  parameter int PG_BITS = 12,
  parameter int P_BIT   = 0,
  parameter int RW_BIT  = 1,
  parameter int US_BIT  = 2,
  parameter int A_BIT   = 5,
  parameter int D_BIT   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [AW-1:0] base_in,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_lin,
  input  logic          req_write,
  input  logic          req_user,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          resp_valid,
  output logic          resp_fault,
  output logic [AW-1:0] resp_paddr,
  output logic [AW-1:0] fault_addr
);
  localparam int FRAME_W = AW - PG_BITS;
  localparam int TBL_W   = PG_BITS - 2;
  localparam int DIR_W   = AW - PG_BITS - TBL_W;
  localparam logic [AW-1:0] PG_MASK = {{FRAME_W{1'b1}}, {PG_BITS{1'b0}}};
  localparam logic [AW-1:0] A_MASK  = AW'(1) << A_BIT;
  localparam logic [AW-1:0] D_MASK  = AW'(1) << D_BIT;

  typedef enum logic [2:0] {S_IDLE, S_RDD, S_WBD, S_RDT, S_WBT} st_t;

  st_t               st;
  logic [AW-1:0]     base_q, lin_q, ent_q;
  logic [FRAME_W-1:0] frame_q;
  logic              wr_q, usr_q, us_d, rw_d;

  wire rd = mem_rdata[P_BIT];
  wire [AW-1:0] dir_addr = (base_q & PG_MASK) | (AW'(lin_q[AW-1 -: DIR_W]) << 2);
  wire [AW-1:0] tbl_addr = {frame_q, {PG_BITS{1'b0}}} | (AW'(lin_q[PG_BITS +: TBL_W]) << 2);

  wire ok_d = rd && (!usr_q || (mem_rdata[US_BIT] && (!wr_q || mem_rdata[RW_BIT])));
  wire ok_t = rd && (!usr_q || (us_d && mem_rdata[US_BIT] &&
                                (!wr_q || (rw_d && mem_rdata[RW_BIT]))));
  wire [AW-1:0] pte_new = mem_rdata | A_MASK | (wr_q ? D_MASK : '0);

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WBD) || (st == S_WBT);
  assign mem_addr  = (st == S_RDD || st == S_WBD) ? dir_addr : tbl_addr;
  assign mem_wdata = (st == S_WBD) ? (ent_q | A_MASK) : (st == S_WBT) ? ent_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      base_q     <= '0;
      lin_q      <= '0;
      ent_q      <= '0;
      frame_q    <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      us_d       <= 1'b0;
      rw_d       <= 1'b0;
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
      fault_addr <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (base_wr) base_q <= base_in & PG_MASK;
      case (st)
        S_IDLE: if (req_valid) begin
          lin_q <= req_lin;
          wr_q  <= req_write;
          usr_q <= req_user;
          st    <= S_RDD;
        end
        S_RDD: if (mem_ack) begin
          ent_q   <= mem_rdata;
          frame_q <= mem_rdata[AW-1:PG_BITS];
          us_d    <= mem_rdata[US_BIT];
          rw_d    <= mem_rdata[RW_BIT];
          if (!ok_d) begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b1;
            resp_paddr <= '0;
            fault_addr <= lin_q;
            st         <= S_IDLE;
          end else if (!mem_rdata[A_BIT]) st <= S_WBD;
          else st <= S_RDT;
        end
        S_WBD: if (mem_ack) st <= S_RDT;
        S_RDT: if (mem_ack) begin
          if (!ok_t) begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b1;
            resp_paddr <= '0;
            fault_addr <= lin_q;
            st         <= S_IDLE;
          end else if (pte_new != mem_rdata) begin
            ent_q <= pte_new;
            st    <= S_WBT;
          end else begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b0;
            resp_paddr <= {mem_rdata[AW-1:PG_BITS], lin_q[PG_BITS-1:0]};
            st         <= S_IDLE;
          end
        end
        S_WBT: if (mem_ack) begin
          resp_valid <= 1'b1;
          resp_fault <= 1'b0;
          resp_paddr <= {ent_q[AW-1:PG_BITS], lin_q[PG_BITS-1:0]};
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int AW      = 32,
  parameter int PG_BITS = 12,
  parameter int P_BIT   = 0,
  parameter int A_BIT   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_lin,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic          resp_valid,
  input logic          resp_fault,
  input logic [AW-1:0] resp_paddr,
  input logic [AW-1:0] fault_addr
);
  logic [AW-1:0] lin_c;
  always_ff @(posedge clk) begin
    if (!rst_n) lin_c <= '0;
    else if (req_valid && req_ready) lin_c <= req_lin;
  end

  p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_fault |-> resp_paddr[PG_BITS-1:0] == lin_c[PG_BITS-1:0]);
  p_wb_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[P_BIT] && mem_wdata[A_BIT]);
  p_fault_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> fault_addr == lin_c);
  p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid && resp_fault) |-> $stable(fault_addr));
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  p_resp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
endmodule

bind pt_walker pt_walker_chk #(.AW(AW), .PG_BITS(PG_BITS), .P_BIT(P_BIT), .A_BIT(A_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .resp_valid(resp_valid), .resp_fault(resp_fault),
  .resp_paddr(resp_paddr), .fault_addr(fault_addr));

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic base_wr = 0, req_valid = 0, req_write = 0, req_user = 0, mem_ack = 0;
  logic [31:0] base_in = 0, req_lin = 0, mem_rdata = 0;
  logic req_ready, mem_req, mem_we, resp_valid, resp_fault;
  logic [31:0] mem_addr, mem_wdata, resp_paddr, fault_addr;

  pt_walker u0 (.*);

  int vectors = 0, errors = 0;
  logic [31:0] mem  [logic [31:0]];
  logic [31:0] rmem [logic [31:0]];
  logic [31:0] q_addr[$], q_data[$];
  logic        q_we[$];
  string       q_tag[$];
  logic [31:0] exp_base = 0, exp_fa = 0, exp_pa;
  logic        exp_flt;
  int lat = 1, cnt = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rget(logic [31:0] a);
    return rmem.exists(a) ? rmem[a] : 32'h0;
  endfunction

  task automatic setw(logic [31:0] a, logic [31:0] v);
    mem[a] = v; rmem[a] = v;
  endtask

  task automatic push(logic [31:0] a, logic we, logic [31:0] d, string tag);
    q_addr.push_back(a); q_we.push_back(we); q_data.push_back(d); q_tag.push_back(tag);
  endtask

  // behavioural reference of one walk
  task automatic predict(logic [31:0] lin, logic wr, logic usr);
    logic [31:0] da, ta, pde, pte, nw;
    da = exp_base + 32'(lin[31:22]) * 4;
    pde = rget(da);
    push(da, 0, 0, "R1");
    exp_flt = 1; exp_pa = 0;
    if (!(pde[0] && (!usr || (pde[2] && (!wr || pde[1]))))) begin exp_fa = lin; return; end
    if (!pde[5]) begin nw = pde | 32'h20; push(da, 1, nw, "R6 R8"); rmem[da] = nw; end
    ta = {pde[31:12], 12'h0} + 32'(lin[21:12]) * 4;
    pte = rget(ta);
    push(ta, 0, 0, "R2");
    if (!(pte[0] && (!usr || (pde[2] && pte[2] && (!wr || (pde[1] && pte[1]))))))
      begin exp_fa = lin; return; end
    nw = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
    if (nw != pte) begin push(ta, 1, nw, "R7"); rmem[ta] = nw; end
    exp_flt = 0; exp_pa = {pte[31:12], lin[11:0]};
  endtask

  // memory model, compares every access against the predicted list
  always @(negedge clk) begin
    if (mem_ack) begin mem_ack = 0; cnt = 0; end
    else if (rst_n && mem_req) begin
      cnt++;
      if (cnt >= lat) begin
        mem_ack = 1;
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        if (q_addr.size() == 0) begin
          vectors++; errors++;
          $display("FAIL R4 actual=unexpected access %h expected=none", mem_addr);
        end else begin
          string t;
          t = q_tag.pop_front();
          chk({t, " addr"}, mem_addr, q_addr.pop_front());
          chk({t, " we"}, 32'(mem_we), 32'(q_we[0]));
          if (q_we.pop_front()) chk({t, " wdata"}, mem_wdata, q_data[0]);
          void'(q_data.pop_front());
        end
        if (mem_we) mem[mem_addr] = mem_wdata;
      end
    end
  end

  task automatic walk(logic [31:0] lin, logic wr, logic usr, string tag);
    int n = 0;
    predict(lin, wr, usr);
    @(negedge clk);
    req_valid = 1; req_lin = lin; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 0;
    while (!resp_valid && n < 300) begin @(negedge clk); n++; end
    if (n >= 300) begin
      vectors++; errors++;
      $display("FAIL %s actual=no response expected=response", tag);
      return;
    end
    chk({tag, " R3/R4/R5 fault"}, 32'(resp_fault), 32'(exp_flt));
    chk({tag, " R3 paddr"}, resp_paddr, exp_pa);
    chk({tag, " R9 fault_addr"}, fault_addr, exp_fa);
    chk({tag, " R4 leftover accesses"}, q_addr.size(), 0);
    q_addr.delete(); q_we.delete(); q_data.delete(); q_tag.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 ready", 32'(req_ready), 1);
    chk("R10 mem_req", 32'(mem_req), 0);
    chk("R10 resp_valid", 32'(resp_valid), 0);
    chk("R10 fault_addr", fault_addr, 0);

    base_wr = 1; base_in = 32'h0001_0ABC;
    @(negedge clk); base_wr = 0; exp_base = 32'h0001_0000;

    // R4: directory not present
    walk(32'h0040_1234, 0, 0, "R4 pde absent");
    // R6 R7: fresh entries, user read
    setw(32'h0001_0004, 32'h0002_0007);
    setw(32'h0002_0004, 32'h0003_4007);
    walk(32'h0040_1234, 0, 1, "R6 R7 first walk");
    walk(32'h0040_1234, 0, 1, "R7 bits already set");
    walk(32'h0040_1FFC, 1, 1, "R7 dirty on write");
    walk(32'h0040_1000, 1, 0, "R7 no rewrite");
    // R4: table entry absent
    walk(32'h0040_2000, 0, 0, "R4 pte absent");
    // R5: user to supervisor page, then supervisor
    setw(32'h0002_0008, 32'h0005_0003);
    walk(32'h0040_2010, 0, 1, "R5 user on supv page");
    walk(32'h0040_2010, 0, 0, "R5 supv on supv page");
    // R5 R8: read-only directory with A=0, user write refused at directory
    setw(32'h0001_0FFC, 32'h0006_0005);
    setw(32'h0006_0FFC, 32'h0007_0007);
    walk(32'hFFFF_F123, 1, 1, "R5 user write ro dir");
    walk(32'hFFFF_F123, 0, 1, "R5 user read ro dir");
    walk(32'hFFFF_F123, 1, 0, "R8 supv write");
    // R1: new base, latencies
    base_wr = 1; base_in = 32'h0008_0FFF;
    @(negedge clk); base_wr = 0; exp_base = 32'h0008_0000;
    setw(32'h0008_0000, 32'h0009_0027);
    setw(32'h0009_0000, 32'h000A_0001);
    for (int l = 1; l <= 3; l++) begin
      lat = l;
      walk(32'h0000_0ABC, l[0], 0, "R1 R10 latency");
    end
    // random walks over a small shared table set
    for (int i = 0; i < 4; i++) begin
      setw(32'h0008_0000 + 32'(i) * 4,
           {20'h00090 + 20'(i), 6'd0, 6'($urandom) & 6'h27 | 6'h01});
      for (int j = 0; j < 4; j++)
        setw({12'h000, 8'h90 + 8'(i), 12'h000} + 32'(j) * 4,
             {20'h0A000 + 20'(i * 4 + j), 6'd0, 6'($urandom) & 6'h67});
    end
    for (int k = 0; k < 60; k++) begin
      lat = 1 + ($urandom % 3);
      walk({10'($urandom % 4), 10'($urandom % 4), 12'($urandom)},
           1'($urandom), 1'($urandom), "R3 R5 R7 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule